// File: doc/BRIEF.md
# Signed Packed-Decimal Add/Subtract Unit

This unit adds or subtracts two signed packed-decimal numbers of 128 bits. Each number carries 31 decimal digits, with the least significant digit just above a 4-bit sign code in the bottom nibble. A subtract select flips the sense of the second operand's sign before the arithmetic. A preferred-sign select chooses which of two codes marks a non-negative result. The unit returns the 31-digit result and a 4-bit condition field.

The condition field describes the true mathematical result, not the truncated one. A sum that carries out of the top digit and wraps to all zeros therefore still reports its direction, along with the overflow flag. Any malformed digit or sign code in either operand reports only the summary flag.

The arithmetic is combinational. The result and condition field are captured in an output register, so both appear one clock after the operands are presented.

Top module: `dec_addsub_unit`

## Requirements
- R1: Operand and result layout: digit k (k = 0 is least significant) sits in bits [4k+7:4k+4], and bits [3:0] hold the sign code.
- R2: Sign codes 0xA, 0xC, 0xE and 0xF are positive, and 0xB and 0xD are negative. A sign code of 0x0–0x9, or any digit nibble above 9, in either operand makes the condition field 0b0001. The result digits are then unspecified.
- R3: Overflow is the carry out of digit 30. The result keeps only the low 31 digits, and bit 0 of the condition field is set.
- R4: A positive or zero result gets sign code 0xC when pref_sign_i is 0 and 0xF when it is 1. A negative result always gets 0xD, whatever pref_sign_i is.
- R5: Condition bits are LT = bit 3, GT = bit 2, EQ = bit 1, SO = bit 0. A zero result gives 0b0010, a positive result 0b0100 and a negative result 0b1000. At most one of bits 3..1 is ever set.
- R6: When the effective signs agree, the magnitudes are added, with a decimal carry per digit, and the result takes the common sign.
- R7: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R8: With sub_sel_i = 1, the unit computes A − B by treating B's sign as inverted.
- R9: Equal magnitudes with differing effective signs give zero with a positive sign code and condition 0b0010. Two zero operands of the same sign also give this result.
- R10: Result and condition appear on the rising clock edge after the inputs are presented. An active-low asynchronous reset clears both to zero.
- R11: Flags follow the unbounded result. A positive overflow gives 0b0101 and a negative overflow gives 0b1001, even when the kept digits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 128 | First signed packed-decimal operand |
| op_b_i | input | 128 | Second signed packed-decimal operand |
| sub_sel_i | input | 1 | 1 selects A − B, 0 selects A + B |
| pref_sign_i | input | 1 | Chooses 0xF (1) or 0xC (0) as the non-negative sign code |
| res_o | output | 128 | Registered 31-digit result with sign code |
| cond_o | output | 4 | Registered condition field {LT, GT, EQ, SO} |

## Verification
The assertions check five properties on every cycle. Invalid operands always yield the lone summary flag. An overflow keeps exactly one direction flag. The output sign code agrees with the direction flags and the preferred-sign input. An EQ result has all-zero digits. The two opposing subtractors in the magnitude core always agree on ordering, and a tie always means a zero difference.

The assertions cannot check the digit values themselves. The bench's vectors show those: decimal carry chains, correct choice of the larger operand, the wrap at the top digit and the resulting kept digits. The bench's directed steps show the one-cycle latency and the reset values.

// File: rtl/dec_pkg.sv
package dec_pkg;

  // Condition field bit positions (neighbouring logic decodes these)
  localparam int CB_LT = 3;
  localparam int CB_GT = 2;
  localparam int CB_EQ = 1;
  localparam int CB_SO = 0;

  localparam logic [3:0] SGN_POS_STD = 4'hC;
  localparam logic [3:0] SGN_POS_ALT = 4'hF;
  localparam logic [3:0] SGN_NEG     = 4'hD;

  typedef enum logic [1:0] {
    SC_BAD = 2'd0,
    SC_POS = 2'd1,
    SC_NEG = 2'd2
  } sgn_cls_t;

  // Classify a sign nibble
  function automatic sgn_cls_t sign_class(input logic [3:0] nib);
    case (nib)
      4'hA, 4'hC, 4'hE, 4'hF: return SC_POS;
      4'hB, 4'hD:             return SC_NEG;
      default:                return SC_BAD;
    endcase
  endfunction

  // One decimal digit add with carry in; returns {carry_out, digit}
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       ci);
    logic [4:0] t;
    t = {1'b0, x} + {1'b0, y} + {4'b0, ci};
    if (t > 5'd9) return {1'b1, 4'(t - 5'd10)};
    else          return {1'b0, t[3:0]};
  endfunction

  // Nine's complement of one digit
  function automatic logic [3:0] nines(input logic [3:0] d);
    return 4'(4'd9 - d);
  endfunction

endpackage

// File: rtl/dec_operand_check.sv
module dec_operand_check
  import dec_pkg::*;
#(
  parameter int NDIG = 31
) (
  input  logic [NDIG*4+3:0] opnd_i,
  input  logic              flip_i,
  output logic              neg_o,
  output logic              bad_o
);

  logic [NDIG-1:0] dig_bad;
  sgn_cls_t        cls;

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_dchk
      assign dig_bad[g] = (opnd_i[g*4+4 +: 4] > 4'd9);
    end
  endgenerate

  assign cls   = sign_class(opnd_i[3:0]);
  assign bad_o = (cls == SC_BAD) || (|dig_bad);
  assign neg_o = (cls == SC_NEG) ^ flip_i;

endmodule

// File: rtl/dec_bcd_ripple.sv
module dec_bcd_ripple
  import dec_pkg::*;
#(
  parameter int NDIG = 31
) (
  input  logic [NDIG*4-1:0] x_i,
  input  logic [NDIG*4-1:0] y_i,
  input  logic              c_i,
  output logic [NDIG*4-1:0] s_o,
  output logic              c_o
);

  logic [NDIG:0] cy;
  assign cy[0] = c_i;

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
      logic [4:0] r;
      assign r            = bcd_digit_add(x_i[g*4 +: 4], y_i[g*4 +: 4], cy[g]);
      assign s_o[g*4 +: 4] = r[3:0];
      assign cy[g+1]      = r[4];
    end
  endgenerate

  assign c_o = cy[NDIG];

endmodule

// File: rtl/dec_mag_core.sv
module dec_mag_core
  import dec_pkg::*;
#(
  parameter int NDIG = 31
) (
  input  logic [NDIG*4-1:0] a_mag_i,
  input  logic [NDIG*4-1:0] b_mag_i,
  input  logic              same_sign_i,
  input  logic              ops_ok_i,
  output logic [NDIG*4-1:0] mag_o,
  output logic              carry_o,
  output logic              a_ge_b_o,
  output logic              zero_o
);

  localparam int MW = NDIG * 4;

  logic [MW-1:0] a_nc, b_nc;
  logic [MW-1:0] sum_s, diff_ab, diff_ba;
  logic          sum_c, ge_ab, ge_ba;

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_nc
      assign a_nc[g*4 +: 4] = nines(a_mag_i[g*4 +: 4]);
      assign b_nc[g*4 +: 4] = nines(b_mag_i[g*4 +: 4]);
    end
  endgenerate

  // Plain magnitude sum
  dec_bcd_ripple #(.NDIG(NDIG)) u_sum (
    .x_i(a_mag_i), .y_i(b_mag_i), .c_i(1'b0), .s_o(sum_s), .c_o(sum_c));

  // |A| - |B| by nine's complement; carry out means |A| >= |B|
  dec_bcd_ripple #(.NDIG(NDIG)) u_dab (
    .x_i(a_mag_i), .y_i(b_nc), .c_i(1'b1), .s_o(diff_ab), .c_o(ge_ab));

  // |B| - |A|; carry out means |B| >= |A|
  dec_bcd_ripple #(.NDIG(NDIG)) u_dba (
    .x_i(b_mag_i), .y_i(a_nc), .c_i(1'b1), .s_o(diff_ba), .c_o(ge_ba));

  always_comb begin
    if (same_sign_i) begin
      mag_o   = sum_s;
      carry_o = sum_c;
    end else begin
      mag_o   = ge_ab ? diff_ab : diff_ba;
      carry_o = 1'b0;
    end
  end

  assign a_ge_b_o = ge_ab;
  // Unbounded zero: kept digits zero and nothing carried past the top
  assign zero_o   = (mag_o == '0) && !carry_o;

  always_comb begin
    AST_ORDER_TOTAL: assert (!ops_ok_i || ge_ab || ge_ba);                     // R7
    AST_TIE_IS_ZERO: assert (!ops_ok_i || !(ge_ab && ge_ba) || diff_ab == '0); // R9
  end

endmodule

// File: rtl/dec_addsub_unit.sv
module dec_addsub_unit
  import dec_pkg::*;
#(
  parameter int NDIG = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NDIG*4+3:0]   op_a_i,
  input  logic [NDIG*4+3:0]   op_b_i,
  input  logic                sub_sel_i,
  input  logic                pref_sign_i,
  output logic [NDIG*4+3:0]   res_o,
  output logic [3:0]          cond_o
);

  localparam int W  = NDIG * 4 + 4;
  localparam int MW = NDIG * 4;

  logic [1:0][W-1:0] opd;
  logic [1:0]        opd_neg, opd_bad;

  assign opd[0] = op_a_i;
  assign opd[1] = op_b_i;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_opd
      dec_operand_check #(.NDIG(NDIG)) u_chk (
        .opnd_i (opd[k]),
        .flip_i ((k == 1) && sub_sel_i),
        .neg_o  (opd_neg[k]),
        .bad_o  (opd_bad[k])
      );
    end
  endgenerate

  // Named internal events
  logic          any_bad, same_sign, mag_carry, a_ge_b, unb_zero, res_neg;
  logic [MW-1:0] mag;
  logic [3:0]    sign_code;
  logic [W-1:0]  res_nxt;
  logic [3:0]    cond_nxt;

  assign any_bad   = |opd_bad;
  assign same_sign = (opd_neg[0] == opd_neg[1]);

  dec_mag_core #(.NDIG(NDIG)) u_core (
    .a_mag_i     (op_a_i[W-1:4]),
    .b_mag_i     (op_b_i[W-1:4]),
    .same_sign_i (same_sign),
    .ops_ok_i    (!any_bad),
    .mag_o       (mag),
    .carry_o     (mag_carry),
    .a_ge_b_o    (a_ge_b),
    .zero_o      (unb_zero)
  );

  always_comb begin
    if (unb_zero)       res_neg = 1'b0;
    else if (same_sign) res_neg = opd_neg[0];
    else                res_neg = a_ge_b ? opd_neg[0] : opd_neg[1];
  end

  assign sign_code = res_neg     ? SGN_NEG :
                     pref_sign_i ? SGN_POS_ALT : SGN_POS_STD;

  always_comb begin
    cond_nxt = '0;
    res_nxt  = {mag, sign_code};
    if (any_bad) begin
      cond_nxt[CB_SO] = 1'b1;
      res_nxt         = '0;
    end else if (unb_zero) begin
      cond_nxt[CB_EQ] = 1'b1;
    end else begin
      cond_nxt[CB_LT] = res_neg;
      cond_nxt[CB_GT] = !res_neg;
      cond_nxt[CB_SO] = mag_carry;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      cond_o <= '0;
    end else begin
      res_o  <= res_nxt;
      cond_o <= cond_nxt;
    end
  end

  AST_INVALID_SO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_bad |=> (cond_o == 4'b0001)); // R2
  AST_OVF_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_bad && mag_carry) |=> (cond_o[CB_SO] && !cond_o[CB_EQ] && (cond_o[CB_LT] != cond_o[CB_GT]))); // R11
  AST_NEG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o[CB_LT] |-> (res_o[3:0] == SGN_NEG)); // R4
  AST_POS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o[CB_GT] || cond_o[CB_EQ]) |-> (res_o[3:0] == ($past(pref_sign_i) ? SGN_POS_ALT : SGN_POS_STD))); // R4
  AST_EQ_DIGITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o[CB_EQ] |-> (res_o[W-1:4] == '0)); // R5
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cond_o[3:1])); // R5

endmodule

// File: tb/sim_dec_addsub_unit.sv
module sim_dec_addsub_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 31;
  localparam int W = NDIG * 4 + 4;

  localparam logic [NDIG*4-1:0] NINES = {NDIG{4'h9}};
  localparam logic [W-1:0] MAXP  = {NINES, 4'hC};
  localparam logic [W-1:0] MAXN  = {NINES, 4'hD};
  localparam logic [W-1:0] ALMST = {{(NDIG-1){4'h9}}, 4'h8, 4'hC};

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic         ps;
    logic         chk;
    logic [W-1:0] er;
    logic [3:0]   ec;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{MAXP,     MAXP,     1'b1, 1'b0, 1'b1, 128'hC,             4'b0010}, // R9 R8 R1
    '{MAXP,     MAXP,     1'b1, 1'b1, 1'b1, 128'hF,             4'b0010}, // R4
    '{MAXP,     128'h1D,  1'b1, 1'b0, 1'b1, 128'hC,             4'b0101}, // R3 R11
    '{MAXP,     128'h1D,  1'b1, 1'b1, 1'b1, 128'hF,             4'b0101}, // R11
    '{ALMST,    128'h1D,  1'b1, 1'b0, 1'b1, MAXP,               4'b0100}, // R3 no carry
    '{ALMST,    128'h1D,  1'b1, 1'b1, 1'b1, {NINES, 4'hF},      4'b0100}, // R4
    '{128'hC,   128'h1C,  1'b1, 1'b0, 1'b1, 128'h1D,            4'b1000}, // R7 R8
    '{MAXN,     128'h1C,  1'b1, 1'b0, 1'b1, 128'hD,             4'b1001}, // R11 R3
    '{128'h1C,  128'hF00, 1'b1, 1'b0, 1'b0, 128'h0,             4'b0001}, // R2 sign 0
    '{128'hF00, 128'h1C,  1'b1, 1'b1, 1'b0, 128'h0,             4'b0001}, // R2
    '{128'hBAD, 128'h1C,  1'b0, 1'b0, 1'b0, 128'h0,             4'b0001}, // R2 bad digit
    '{128'h123C,128'h456C,1'b0, 1'b0, 1'b1, 128'h579C,          4'b0100}, // R6
    '{128'h500C,128'h123D,1'b0, 1'b0, 1'b1, 128'h377C,          4'b0100}, // R7
    '{128'h123C,128'h500D,1'b0, 1'b1, 1'b1, 128'h377D,          4'b1000}, // R7 R4
    '{128'h995C,128'h7C,  1'b0, 1'b0, 1'b1, 128'h1002C,         4'b0100}, // R6 carry chain
    '{128'h25A, 128'h7B,  1'b0, 1'b0, 1'b1, 128'h18C,           4'b0100}, // R2 codes A B
    '{128'hD,   128'hD,   1'b0, 1'b0, 1'b1, 128'hC,             4'b0010}, // R5 R9
    '{128'h123D,128'h456D,1'b1, 1'b0, 1'b1, 128'h333C,          4'b0100}, // R8
    '{128'h456E,128'h456D,1'b0, 1'b1, 1'b1, 128'hF,             4'b0010}, // R9
    '{128'h123B,128'h877D,1'b0, 1'b0, 1'b1, 128'h1000D,         4'b1000}  // R6 negative
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         sub = 1'b0, ps = 1'b0;
  logic [W-1:0] res;
  logic [3:0]   cond;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_addsub_unit #(.NDIG(NDIG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
    .sub_sel_i(sub), .pref_sign_i(ps), .res_o(res), .cond_o(cond));

  task automatic chk_res(input string req, input logic [W-1:0] exp);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s result got %h exp %h", req, res, exp);
    end
  endtask

  task automatic chk_cond(input string req, input logic [3:0] exp);
    n_run++;
    if (cond !== exp) begin
      n_fail++;
      $display("FAIL %s cond got %b exp %b", req, cond, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired, got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_res("R10 reset", '0);
    chk_cond("R10 reset", 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = VECS[i].a; b = VECS[i].b; sub = VECS[i].sub; ps = VECS[i].ps;
      @(negedge clk);
      if (VECS[i].chk) chk_res($sformatf("vec%0d", i), VECS[i].er);
      chk_cond($sformatf("vec%0d", i), VECS[i].ec);
    end

    // R10: output holds old value until the next rising edge
    @(negedge clk);
    a = 128'h2C; b = 128'h3C; sub = 1'b0; ps = 1'b0;
    #1;
    chk_res("R10 latency hold", 128'h1000D);
    @(negedge clk);
    chk_res("R10 latency update", 128'h5C);
    chk_cond("R10 latency update", 4'b0100);

    // R10: asynchronous reset mid-run clears outputs
    #2 rst_n = 1'b0;
    #1;
    chk_res("R10 async reset", '0);
    chk_cond("R10 async reset", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: largest plus largest keeps low digits 9..98, overflow with GT
    a = MAXP; b = MAXP; sub = 1'b0; ps = 1'b0;
    @(negedge clk);
    chk_res("R3 wrap digits", {{(NDIG-1){4'h9}}, 4'h8, 4'hC});
    chk_cond("R3 wrap flags", 4'b0101);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule